// File: doc/BRIEF.md
# Flow-Controlled Serial Transmitter

This block serialises one character at a time onto an asynchronous serial line. The character size is 7, 8 or 9 bits, chosen by a two-bit length code. Each bit is held for sixteen pulses of an oversample tick supplied from outside. Besides ordinary characters, the block can put an all-ones idle frame or an all-zeros break frame on the line on request. A break is always followed by two stop bits.

Flow control acts at two points. A clear-to-send input, when high, keeps a new frame from starting, but it never cuts off a frame that has already begun. A driver-enable output keys an external RS485 line driver. It covers the whole frame and is held for one extra bit time after the final stop bit. The line level can be inverted. An output-enable follows the transmitter enable, so the pin is released while the block is disabled.

A client watches `ready`, places a character on `data` and pulses one of the three request inputs for one clock.

Top module: `uart_flow_tx`

## Requirements
- R1: The length code selects the character size: 2'b10 gives 7 bits, 2'b00 gives 8 bits and 2'b01 gives 9 bits, and 2'b11 is treated as 8 bits. A character frame is one start bit, then the data bits LSB first (data[0] first), then one stop bit. Each bit lasts 16 tick pulses, counted from the clock edge that accepts the request.
- R2: While the block is enabled and not sending, tx_out rests at the stop level (1 when invert is 0).
- R3: tx_oe equals tx_en. Dropping tx_en abandons any frame in progress at once, and requests are ignored while tx_en is low.
- R4: On the uninverted line the start bit is 0 and the stop bit is 1. With invert = 1 every level on tx_out, including the resting level, is complemented.
- R5: An idle request sends the character size plus 2 bit times at the stop level.
- R6: A break request drives the start level for the character size plus 2 bit times, then sends exactly 2 stop bits.
- R7: While cts is high no new frame starts, but a frame already in progress runs to its last stop bit unchanged.
- R8: ready is 1 only when tx_en is 1, no frame is in progress and cts is 0. A request made while ready is 0 has no effect.
- R9: When several requests arrive in the same cycle, break wins over idle, and idle wins over a character.
- R10: With rs485_en = 1, de is 1 from the accepting edge until 16 ticks after the last stop bit ends. With rs485_en = 0, de stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversample tick, 16 per bit |
| tx_en | input | 1 | Transmitter enable |
| len_code | input | 2 | Character size code |
| invert | input | 1 | Invert line levels |
| rs485_en | input | 1 | Enable driver-enable output |
| cts | input | 1 | Clear to send, high blocks new frames |
| req_char | input | 1 | Send the character on data |
| req_idle | input | 1 | Send an idle frame |
| req_brk | input | 1 | Send a break frame |
| data | input | 9 | Character, LSB sent first |
| ready | output | 1 | A request would be accepted now |
| tx_out | output | 1 | Serial line |
| tx_oe | output | 1 | Pin output enable |
| de | output | 1 | External transceiver driver enable |

## Verification
The bench sweeps every length code, both polarities and several data patterns, including all-ones and all-zeros characters. It also runs with the tick arriving every one, two and three clocks. A design that miscounts the reserved code or sends data MSB first would drop or swap a bit in the middle. A break that appended one stop bit, or one that used the ordinary frame length, would shift where the line returns high. Other faults the bench looks for:
- A frame cut short when cts rises.
- A request taken while cts is high or while the block is disabled.
- A wrong priority among simultaneous requests.
- de dropping with the stop bit instead of one bit later, which a check on the 15th and 16th ticks after the frame separates.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int unsigned DATA_MAX = 9;
  localparam int unsigned FRAME_W  = DATA_MAX + 4;
  localparam int unsigned CNT_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {K_CHAR, K_IDLE, K_BREAK} kind_e;
  typedef enum logic {S_IDLE, S_SEND} st_e;

  function automatic logic [3:0] char_len(input logic [1:0] code);
    case (code)
      2'b10:   return 4'd7;
      2'b01:   return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_done
);
  localparam int unsigned W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  assign at_end   = (cnt_q == W'(OVS - 1));
  assign bit_done = run & tick & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = at_end ? '0 : cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: a finished bit restarts the oversample count
  p_bit_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> (cnt_q == '0));
endmodule

// File: rtl/uft_frame_build.sv
module uft_frame_build
  import uft_pkg::*;
(
  input  kind_e                kind,
  input  logic [1:0]           len_code,
  input  logic [DATA_MAX-1:0]  data,
  output logic [FRAME_W-1:0]   pattern,
  output logic [CNT_W-1:0]     nbits
);
  logic [3:0] n;

  assign n = char_len(len_code);

  always_comb begin
    pattern = '1;
    nbits   = CNT_W'(n) + CNT_W'(2);
    case (kind)
      K_CHAR: begin
        pattern[0] = 1'b0;
        for (int i = 0; i < int'(DATA_MAX); i++) begin
          if (i < int'(n)) pattern[i+1] = data[i];
        end
      end
      K_BREAK: begin
        for (int i = 0; i < int'(FRAME_W); i++) begin
          if (i < int'(n) + 2) pattern[i] = 1'b0;
        end
        nbits = CNT_W'(n) + CNT_W'(4);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uft_de_hold.sv
module uft_de_hold #(
  parameter int unsigned OVS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic busy,
  input  logic frame_end,
  input  logic rs485_en,
  output logic de
);
  localparam int unsigned W = (OVS > 1) ? $clog2(OVS) : 1;

  logic         hold_q, hold_d;
  logic [W-1:0] hcnt_q, hcnt_d;

  always_comb begin
    hold_d = hold_q;
    hcnt_d = hcnt_q;
    if (frame_end) begin
      hold_d = 1'b1;
      hcnt_d = '0;
    end else if (!enable || busy) begin
      hold_d = 1'b0;
      hcnt_d = '0;
    end else if (hold_q && tick) begin
      if (hcnt_q == W'(OVS - 1)) begin
        hold_d = 1'b0;
        hcnt_d = '0;
      end else begin
        hcnt_d = hcnt_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      hcnt_q <= '0;
    end else begin
      hold_q <= hold_d;
      hcnt_q <= hcnt_d;
    end
  end

  assign de = rs485_en & (busy | hold_q);

  // R10: the tail counter only runs during the hold window
  p_hold_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |-> (hcnt_q == '0));
endmodule

// File: rtl/uart_flow_tx.sv
module uart_flow_tx
  import uft_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                tx_en,
  input  logic [1:0]          len_code,
  input  logic                invert,
  input  logic                rs485_en,
  input  logic                cts,
  input  logic                req_char,
  input  logic                req_idle,
  input  logic                req_brk,
  input  logic [DATA_MAX-1:0] data,
  output logic                ready,
  output logic                tx_out,
  output logic                tx_oe,
  output logic                de
);
  st_e                state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;

  kind_e              kind_sel;
  logic [FRAME_W-1:0] pattern;
  logic [CNT_W-1:0]   nbits;
  logic               busy, accept, bit_done, last_bit, frame_end;

  assign busy      = (state_q == S_SEND);
  assign ready     = tx_en & ~busy & ~cts;
  assign accept    = ready & (req_char | req_idle | req_brk);
  assign kind_sel  = req_brk ? K_BREAK : (req_idle ? K_IDLE : K_CHAR);
  assign last_bit  = (left_q == CNT_W'(1));
  assign frame_end = bit_done & last_bit & tx_en;

  uft_frame_build u_build (
    .kind     (kind_sel),
    .len_code (len_code),
    .data     (data),
    .pattern  (pattern),
    .nbits    (nbits)
  );

  uft_bit_timer #(.OVS(OVS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .tick     (tick),
    .bit_done (bit_done)
  );

  uft_de_hold #(.OVS(OVS)) u_de (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (tx_en),
    .busy      (busy),
    .frame_end (frame_end),
    .rs485_en  (rs485_en),
    .de        (de)
  );

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    left_d  = left_q;
    if (!tx_en) begin
      state_d = S_IDLE;
      left_d  = '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            state_d = S_SEND;
            sh_d    = pattern;
            left_d  = nbits;
          end
        end
        S_SEND: begin
          if (bit_done) begin
            if (last_bit) begin
              state_d = S_IDLE;
              left_d  = '0;
            end else begin
              sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
              left_d = left_q - CNT_W'(1);
            end
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sh_q    <= '1;
      left_q  <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      left_q  <= left_d;
    end
  end

  assign tx_out = (busy ? sh_q[0] : 1'b1) ^ invert;
  assign tx_oe  = tx_en;

  // R2: the resting line sits at the stop level
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !busy) |-> (tx_out == ~invert));
  // R7: while cts is high an idle transmitter stays idle
  p_cts_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cts && !busy) |=> !busy);
  // R10: the driver is keyed for every bit of a frame
  p_de_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rs485_en && busy) |-> de);
  // R1: a frame in flight always has bits left to send
  p_left_live_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left_q != '0));
  // R3: disabling ends the frame on the next edge
  p_disable_idles_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !busy);
endmodule

// File: tb/tb_uart_flow_tx.sv
`timescale 1ns/1ps
module tb_uart_flow_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       tx_en, invert, rs485_en, cts;
  logic [1:0] len_code;
  logic       req_char, req_idle, req_brk;
  logic [8:0] data;
  logic       ready, tx_out, tx_oe, de;

  int checks = 0;
  int errors = 0;
  int tdiv   = 1;
  int tph    = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  uart_flow_tx dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_en(tx_en), .len_code(len_code),
    .invert(invert), .rs485_en(rs485_en), .cts(cts), .req_char(req_char),
    .req_idle(req_idle), .req_brk(req_brk), .data(data), .ready(ready),
    .tx_out(tx_out), .tx_oe(tx_oe), .de(de)
  );

  always @(negedge clk) begin
    tph  = (tph + 1) % tdiv;
    tick = (tph == 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] build_exp(input int kind, input int code,
                                            input logic [8:0] d, output int nb);
    int n = (code == 2) ? 7 : ((code == 1) ? 9 : 8);
    logic [15:0] e = '1;
    nb = n + 2;
    if (kind == 0) begin
      e[0] = 1'b0;
      for (int i = 0; i < n; i++) e[i+1] = d[i];
    end else if (kind == 2) begin
      for (int i = 0; i < n + 2; i++) e[i] = 1'b0;
      nb = n + 4;
    end
    return e;
  endfunction

  task automatic start(input int kind, input logic [8:0] d, input string req);
    @(negedge clk);
    chk(req, "ready before request", ready, 1);
    data     = d;
    req_char = (kind == 0);
    req_idle = (kind == 1);
    req_brk  = (kind == 2);
    @(posedge clk);
    #1;
    req_char = 1'b0;
    req_idle = 1'b0;
    req_brk  = 1'b0;
  endtask

  task automatic run_frame(input logic [15:0] exp, input int nb,
                           input int ready_after, input string req);
    int t = 0;
    while (t < 16 * nb) begin
      @(posedge clk);
      if (tick) begin
        t++;
        if (t % 16 == 8) begin
          @(negedge clk);
          chk(req, "line bit", tx_out, exp[t/16] ^ invert);
          chk("R10", "de during frame", de, rs485_en);
        end
      end
    end
    @(negedge clk);
    chk("R8", "ready after frame", ready, ready_after);
    chk("R2", "rest level after frame", tx_out, !invert);
    t = 0;
    while (t < 16) begin
      @(posedge clk);
      if (tick) begin
        t++;
        if (t == 15) begin
          @(negedge clk);
          chk("R10", "de held one bit", de, rs485_en);
        end
      end
    end
    @(negedge clk);
    chk("R10", "de released", de, 0);
  endtask

  initial begin
    logic [8:0] pats[4] = '{9'h155, 9'h0AA, 9'h1FF, 9'h000};
    logic [15:0] e;
    int nb;
    rst_n = 1'b0; tx_en = 1'b0; invert = 1'b0; rs485_en = 1'b1; cts = 1'b0;
    len_code = 2'b00; req_char = 1'b0; req_idle = 1'b0; req_brk = 1'b0; data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "tx_oe after reset", tx_oe, 0);
    chk("R8", "ready while disabled", ready, 0);
    chk("R10", "de after reset", de, 0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R3", "tx_oe enabled", tx_oe, 1);
    chk("R8", "ready when idle", ready, 1);
    chk("R2", "rest level", tx_out, 1);

    // R1 R4: characters over all codes, polarities and patterns
    for (int c = 0; c < 4; c++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int p = 0; p < 4; p++) begin
          tdiv = (p == 3) ? 3 : 1;
          len_code = 2'(c); invert = inv[0]; rs485_en = p[0];
          e = build_exp(0, c, pats[p], nb);
          start(0, pats[p], "R1");
          run_frame(e, nb, 1, (inv != 0) ? "R4" : "R1");
        end
      end
    end

    // R5 R6: idle and break frames
    tdiv = 2;
    rs485_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      for (int inv = 0; inv < 2; inv++) begin
        len_code = 2'(c); invert = inv[0];
        e = build_exp(1, c, 9'h000, nb);
        start(1, 9'h000, "R5");
        run_frame(e, nb, 1, "R5");
        e = build_exp(2, c, 9'h1FF, nb);
        start(2, 9'h1FF, "R6");
        run_frame(e, nb, 1, "R6");
      end
    end

    // R9: priority among simultaneous requests
    tdiv = 1; invert = 1'b0; len_code = 2'b10;
    @(negedge clk);
    data = 9'h0F0; req_char = 1'b1; req_idle = 1'b1; req_brk = 1'b1;
    @(posedge clk); #1;
    req_char = 1'b0; req_idle = 1'b0; req_brk = 1'b0;
    e = build_exp(2, 2, 9'h0F0, nb);
    run_frame(e, nb, 1, "R9");
    @(negedge clk);
    data = 9'h000; req_char = 1'b1; req_idle = 1'b1;
    @(posedge clk); #1;
    req_char = 1'b0; req_idle = 1'b0;
    e = build_exp(1, 2, 9'h000, nb);
    run_frame(e, nb, 1, "R9");

    // R7: cts rising mid-frame lets the frame finish
    len_code = 2'b00;
    e = build_exp(0, 0, 9'h0C3, nb);
    start(0, 9'h0C3, "R7");
    cts = 1'b1;
    run_frame(e, nb, 0, "R7");
    // R8: request while blocked is ignored
    @(negedge clk);
    data = 9'h000; req_char = 1'b1;
    @(negedge clk);
    req_char = 1'b0;
    begin
      int bad = 0;
      repeat (40) begin
        @(negedge clk);
        if (tx_out !== 1'b1) bad++;
      end
      chk("R8", "line quiet after blocked request", bad, 0);
    end
    chk("R7", "ready while cts high", ready, 0);
    cts = 1'b0;
    @(negedge clk);
    chk("R7", "ready after cts low", ready, 1);

    // R3: disable aborts a frame and blocks requests
    start(0, 9'h000, "R3");
    repeat (30) @(negedge clk);
    chk("R3", "line low mid-frame", tx_out, 0);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R3", "tx_oe disabled", tx_oe, 0);
    chk("R3", "ready disabled", ready, 0);
    chk("R10", "de after abort", de, 0);
    req_char = 1'b1;
    @(negedge clk);
    req_char = 1'b0;
    tx_en = 1'b1;
    begin
      int bad = 0;
      repeat (20) begin
        @(negedge clk);
        if (tx_out !== 1'b1) bad++;
      end
      chk("R3", "line rests after abort", bad, 0);
    end
    chk("R3", "ready after re-enable", ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule